// File: doc/BRIEF.md
# SPI EEPROM Boot Sequencer

After a power-on reset or a software reset, this block reads three boot-mode pins once and decides how the chip starts. In the two serial modes it drives a single active-low chip select to an SPI EEPROM. It sends the read opcode and an all-zero address, which is one or two bytes wide depending on the mode. It then reads a four-byte length header and copies that many bytes into internal memory, starting at offset zero. When the last byte is stored it releases the chip select and pulses a jump request to the start of internal memory.

The remaining pin codes do not touch the serial bus:
- One code requests execution from external 16-bit memory.
- One code hands the chip over to a parallel flash loader that lives elsewhere.
- The upper four codes are rejected with an error flag.

A configuration bit set by software can make a software reset skip loading altogether and jump straight to internal memory. A power-on reset ignores that bit.

Top module: `eeprom_boot_ctrl`

## Requirements
- R1: Mode pins are sampled in the first clock after power-on reset is released and in the clock after a software reset pulse. After a power-on reset the skip bit `skip_on_soft` has no effect.
- R2: Mode 3'b000 produces one single-cycle `boot_go` with `boot_target` = 32'h0200_0000 and never asserts `spi_cs_n`.
- R3: Modes 3'b100 through 3'b111 set `mode_err`, never assert `spi_cs_n`, produce no `boot_go` and no memory write.
- R4: The serial bus runs in SPI mode 0, most significant bit first. `spi_sck` idles low, `spi_mosi` changes only on falling edges, and `spi_miso` is captured on rising edges.
- R5: In mode 3'b010 the first bytes shifted out are 8'h03 and then one 8'h00 address byte. In mode 3'b011 they are 8'h03 and then two 8'h00 bytes.
- R6: After the address, four bytes are read as the load length, most significant byte first. Exactly that many following bytes are written with one `mem_we` pulse each, at addresses 0, 1, 2, ... in arrival order.
- R7: `spi_cs_n` falls once per load and stays low until the final payload byte. It is high in the cycle of the `boot_go` pulse, and `boot_target` is then 32'h0000_0000.
- R8: A length of zero releases `spi_cs_n` after the header and pulses `boot_go` to 32'h0000_0000 without any memory write.
- R9: A `sw_rst` pulse aborts any transfer, so `spi_cs_n` is high on the next clock. The pins are then sampled again.
- R10: A software reset while `skip_on_soft` is 1 pulses `boot_go` to 32'h0000_0000 with no serial activity and no write.
- R11: Mode 3'b001 raises `flash_sel`, with no serial activity and no `boot_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_rst | input | 1 | Synchronous software reset pulse |
| mode_pins | input | 3 | Boot mode selection pins |
| skip_on_soft | input | 1 | Software-set bit: bypass loading on software reset |
| spi_cs_n | output | 1 | EEPROM chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to EEPROM |
| spi_miso | input | 1 | Serial data from EEPROM |
| mem_we | output | 1 | Internal memory write strobe |
| mem_addr | output | MEM_AW | Internal memory write address |
| mem_wdata | output | 8 | Internal memory write data |
| boot_go | output | 1 | One-cycle jump request |
| boot_target | output | 32 | Jump address, valid with boot_go |
| flash_sel | output | 1 | Parallel flash loader selected |
| mode_err | output | 1 | Reserved mode selected |

## Verification
The bench builds the block with `SCK_DIV` = 2 and `MEM_AW` = 8. The short serial clock keeps a 256-byte load within a few thousand cycles. The 256-entry address space means that load fills memory exactly, and its header needs a nonzero second byte, so byte order within the length is exercised. The length order stays at its default, most significant byte first. Both address widths, the zero-length header and an abort in the middle of the command are all reached through a behavioural EEPROM model.

// File: rtl/eeprom_boot_pkg.sv
package eeprom_boot_pkg;

   typedef enum logic [1:0] {
      BK_EXT   = 2'd0,
      BK_FLASH = 2'd1,
      BK_SPI   = 2'd2,
      BK_RSVD  = 2'd3
   } boot_kind_t;

   typedef enum logic [2:0] {
      ST_SAMPLE = 3'd0,
      ST_CMD    = 3'd1,
      ST_ADDR   = 3'd2,
      ST_LEN    = 3'd3,
      ST_DATA   = 3'd4,
      ST_HALT   = 3'd5
   } seq_state_t;

   localparam logic [7:0] RD_OPCODE = 8'h03;

endpackage

// File: rtl/boot_mode_decode.sv
module boot_mode_decode
   import eeprom_boot_pkg::*;
(
   input  logic [2:0] mode,
   output boot_kind_t kind,
   output logic [1:0] addr_bytes
);

   always_comb begin
      kind       = BK_RSVD;
      addr_bytes = 2'd1;
      case (mode)
         3'b000:  kind = BK_EXT;
         3'b001:  kind = BK_FLASH;
         3'b010:  begin kind = BK_SPI; addr_bytes = 2'd1; end
         3'b011:  begin kind = BK_SPI; addr_bytes = 2'd2; end
         default: kind = BK_RSVD;
      endcase
   end

endmodule

// File: rtl/spi_byte_xfer.sv
module spi_byte_xfer #(
   parameter int SCK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       start,
   input  logic [7:0] tx,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx
);

   localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_DIV - 1);

   if (SCK_DIV < 1) begin : g_bad_div
      $error("spi_byte_xfer: SCK_DIV must be at least 1");
   end

   logic [DIV_W-1:0] div_cnt;
   logic [2:0]       bit_cnt;
   logic [7:0]       sh;
   logic             tick;

   assign tick = (div_cnt == DIV_LAST);
   assign mosi = sh[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt <= '0;
         bit_cnt <= '0;
         sh      <= '0;
         sck     <= 1'b0;
         busy    <= 1'b0;
         done    <= 1'b0;
         rx      <= '0;
      end else begin
         done <= 1'b0;
         if (clear) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            div_cnt <= '0;
            sh      <= '0;
         end else if (start && !busy) begin
            busy    <= 1'b1;
            sh      <= tx;
            bit_cnt <= '0;
            div_cnt <= '0;
            sck     <= 1'b0;
         end else if (busy) begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
               if (!sck) begin
                  sck <= 1'b1;
                  rx  <= {rx[6:0], miso};
               end else begin
                  sck <= 1'b0;
                  sh  <= {sh[6:0], 1'b0};
                  if (bit_cnt == 3'd7) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
            end
         end
      end
   end

   assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck) && !$past(clear)) |-> $stable(mosi));

endmodule

// File: rtl/eeprom_boot_ctrl.sv
module eeprom_boot_ctrl
   import eeprom_boot_pkg::*;
#(
   parameter int          SCK_DIV       = 4,
   parameter int          MEM_AW        = 16,
   parameter int          LEN_BYTES     = 4,
   parameter bit          LEN_MSB_FIRST = 1'b1,
   parameter logic [31:0] EXT_BASE      = 32'h0200_0000,
   parameter logic [31:0] INT_BASE      = 32'h0000_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic [2:0]        mode_pins,
   input  logic              skip_on_soft,
   output logic              spi_cs_n,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              boot_go,
   output logic [31:0]       boot_target,
   output logic              flash_sel,
   output logic              mode_err
);

   localparam int LEN_W = 8 * LEN_BYTES;
   localparam int CNT_W = $clog2(LEN_BYTES + 1);

   if (LEN_BYTES < 1 || LEN_BYTES > 4) begin : g_bad_len
      $error("eeprom_boot_ctrl: LEN_BYTES must lie in 1..4");
   end
   if (MEM_AW < 1 || MEM_AW > 32) begin : g_bad_aw
      $error("eeprom_boot_ctrl: MEM_AW must lie in 1..32");
   end

   boot_kind_t       kind;
   logic [1:0]       addr_bytes;
   seq_state_t       state;
   logic             soft_q;
   logic [1:0]       addr_q;
   logic [CNT_W-1:0] cnt;
   logic [LEN_W-1:0] len_q;
   logic [LEN_W-1:0] len_next;
   logic [LEN_W-1:0] remain;
   logic [MEM_AW-1:0] wr_ptr;
   logic             x_start;
   logic [7:0]       x_tx;
   logic             x_busy;
   logic             x_done;
   logic [7:0]       x_rx;

   boot_mode_decode i_decode (
      .mode       (mode_pins),
      .kind       (kind),
      .addr_bytes (addr_bytes)
   );

   spi_byte_xfer #(.SCK_DIV(SCK_DIV)) i_xfer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (sw_rst),
      .start (x_start),
      .tx    (x_tx),
      .miso  (spi_miso),
      .sck   (spi_sck),
      .mosi  (spi_mosi),
      .busy  (x_busy),
      .done  (x_done),
      .rx    (x_rx)
   );

   if (LEN_BYTES == 1) begin : g_len_one
      assign len_next = x_rx;
   end else if (LEN_MSB_FIRST) begin : g_len_msb
      assign len_next = {len_q[LEN_W-9:0], x_rx};
   end else begin : g_len_lsb
      assign len_next = {x_rx, len_q[LEN_W-1:8]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_SAMPLE;
         soft_q      <= 1'b0;
         addr_q      <= 2'd1;
         cnt         <= '0;
         len_q       <= '0;
         remain      <= '0;
         wr_ptr      <= '0;
         x_start     <= 1'b0;
         x_tx        <= '0;
         spi_cs_n    <= 1'b1;
         mem_we      <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         boot_go     <= 1'b0;
         boot_target <= '0;
         flash_sel   <= 1'b0;
         mode_err    <= 1'b0;
      end else begin
         x_start <= 1'b0;
         mem_we  <= 1'b0;
         boot_go <= 1'b0;
         if (sw_rst) begin
            state    <= ST_SAMPLE;
            soft_q   <= 1'b1;
            spi_cs_n <= 1'b1;
         end else begin
            case (state)
               ST_SAMPLE: begin
                  soft_q    <= 1'b0;
                  flash_sel <= 1'b0;
                  mode_err  <= 1'b0;
                  addr_q    <= addr_bytes;
                  if (soft_q && skip_on_soft) begin
                     boot_go     <= 1'b1;
                     boot_target <= INT_BASE;
                     state       <= ST_HALT;
                  end else begin
                     case (kind)
                        BK_EXT: begin
                           boot_go     <= 1'b1;
                           boot_target <= EXT_BASE;
                           state       <= ST_HALT;
                        end
                        BK_FLASH: begin
                           flash_sel <= 1'b1;
                           state     <= ST_HALT;
                        end
                        BK_SPI: begin
                           spi_cs_n <= 1'b0;
                           x_start  <= 1'b1;
                           x_tx     <= RD_OPCODE;
                           state    <= ST_CMD;
                        end
                        default: begin
                           mode_err <= 1'b1;
                           state    <= ST_HALT;
                        end
                     endcase
                  end
               end
               ST_CMD: begin
                  if (x_done) begin
                     x_start <= 1'b1;
                     x_tx    <= 8'h00;
                     cnt     <= CNT_W'(addr_q - 2'd1);
                     state   <= ST_ADDR;
                  end
               end
               ST_ADDR: begin
                  if (x_done) begin
                     x_start <= 1'b1;
                     if (cnt == '0) begin
                        cnt   <= CNT_W'(LEN_BYTES - 1);
                        state <= ST_LEN;
                     end else begin
                        cnt <= cnt - 1'b1;
                     end
                  end
               end
               ST_LEN: begin
                  if (x_done) begin
                     len_q <= len_next;
                     if (cnt == '0) begin
                        if (len_next == '0) begin
                           spi_cs_n    <= 1'b1;
                           boot_go     <= 1'b1;
                           boot_target <= INT_BASE;
                           state       <= ST_HALT;
                        end else begin
                           remain  <= len_next;
                           wr_ptr  <= '0;
                           x_start <= 1'b1;
                           state   <= ST_DATA;
                        end
                     end else begin
                        cnt     <= cnt - 1'b1;
                        x_start <= 1'b1;
                     end
                  end
               end
               ST_DATA: begin
                  if (x_done) begin
                     mem_we    <= 1'b1;
                     mem_addr  <= wr_ptr;
                     mem_wdata <= x_rx;
                     wr_ptr    <= wr_ptr + 1'b1;
                     if (remain == LEN_W'(1)) begin
                        spi_cs_n    <= 1'b1;
                        boot_go     <= 1'b1;
                        boot_target <= INT_BASE;
                        state       <= ST_HALT;
                     end else begin
                        remain  <= remain - 1'b1;
                        x_start <= 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_err_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> (spi_cs_n && !mem_we && !boot_go));

   assert_go_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      boot_go |=> !boot_go);

   assert_cs_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {ST_CMD, ST_ADDR, ST_LEN, ST_DATA}) |-> !spi_cs_n);

   assert_go_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      boot_go |-> spi_cs_n);

   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> (spi_cs_n && !x_busy));

   assert_sck_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_sck |-> !spi_cs_n);

endmodule

// File: tb/test_eeprom_boot_ctrl.sv
module test_eeprom_boot_ctrl;

   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_rst = 1'b0;
   logic [2:0]    mode_pins = 3'b000;
   logic          skip_on_soft = 1'b0;
   logic          spi_cs_n, spi_sck, spi_mosi;
   logic          spi_miso = 1'b0;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic          boot_go;
   logic [31:0]   boot_target;
   logic          flash_sel, mode_err;

   always #10 clk = ~clk;

   eeprom_boot_ctrl #(.SCK_DIV(2), .MEM_AW(AW)) i_eeprom_boot_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .mode_pins(mode_pins),
      .skip_on_soft(skip_on_soft), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .boot_go(boot_go),
      .boot_target(boot_target), .flash_sel(flash_sel), .mode_err(mode_err)
   );

   int checks = 0;
   int fails  = 0;
   int go_cnt = 0;
   logic [31:0] go_tgt = '0;
   logic        cs_at_go = 1'b0;
   int cs_falls = 0;
   int bitn = 0;
   int abytes = 1;
   logic [7:0] shv = '0;
   logic [7:0] img [0:299];
   logic [7:0] cap_q [$];
   logic [15:0] exp_q [$];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // EEPROM model: SPI mode 0, captures on rising, drives on falling
   always @(negedge spi_cs_n) begin
      bitn = 0;
      cap_q.delete();
      cs_falls++;
   end

   always @(posedge spi_sck) if (!spi_cs_n) begin
      shv = {shv[6:0], spi_mosi};
      bitn++;
      if (bitn % 8 == 0) cap_q.push_back(shv);
   end

   always @(negedge spi_sck) if (!spi_cs_n) begin
      int k;
      k = bitn - 8 * (1 + abytes);
      if (k >= 0 && k / 8 < 300) spi_miso = img[k/8][7 - (k % 8)];
      else spi_miso = 1'b0;
   end

   // Monitor: scoreboard for writes, recorder for jumps
   always @(negedge clk) if (rst_n) begin
      if (mem_we) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 0);
         end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            check({mem_addr, mem_wdata} == e, "R6 write addr/data", {mem_addr, mem_wdata}, e);
         end
      end
      if (boot_go) begin
         go_cnt++;
         go_tgt = boot_target;
         cs_at_go = spi_cs_n;
      end
   end

   task automatic clear_obs();
      go_cnt = 0; cs_falls = 0; exp_q.delete(); cap_q.delete();
   endtask

   task automatic por(input logic [2:0] m);
      @(negedge clk);
      rst_n = 1'b0;
      mode_pins = m;
      clear_obs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic soft_reset();
      @(negedge clk);
      sw_rst = 1'b1;
      @(negedge clk);
      sw_rst = 1'b0;
   endtask

   task automatic wait_go(input int limit);
      for (int i = 0; i < limit && go_cnt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Driver: builds the image and pushes the expected writes
   task automatic load_img(input int len, input int salt);
      img[0] = len[31:24]; img[1] = len[23:16]; img[2] = len[15:8]; img[3] = len[7:0];
      for (int i = 0; i < 296; i++) img[4 + i] = 8'((i * 7 + salt) & 8'hff);
      for (int i = 0; i < len; i++) exp_q.push_back({8'(i), img[4 + i]});
   endtask

   task automatic run_spi(input logic [2:0] m, input int ab, input int len, input int salt, input string req);
      por(m);
      abytes = ab;
      load_img(len, salt);
      wait_go(20000);
      check(cap_q.size() > ab, {req, " R5 bytes out"}, cap_q.size(), ab + 1);
      if (cap_q.size() > ab) begin
         check(cap_q[0] == 8'h03, {req, " R5 opcode"}, cap_q[0], 8'h03);
         for (int i = 1; i <= ab; i++) check(cap_q[i] == 8'h00, {req, " R5 address byte"}, cap_q[i], 0);
      end
      check(go_cnt == 1, {req, " R7 one jump"}, go_cnt, 1);
      check(go_tgt == 32'h0, {req, " R7 internal target"}, go_tgt, 0);
      check(cs_at_go == 1'b1, {req, " R7 cs released at jump"}, cs_at_go, 1);
      check(cs_falls == 1, {req, " R7 single select"}, cs_falls, 1);
      check(exp_q.size() == 0, {req, " R6 all bytes written"}, exp_q.size(), 0);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      // R1 reset state
      repeat (2) @(negedge clk);
      check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 reset bus idle", {spi_cs_n, spi_sck}, 2'b10);
      check(boot_go == 1'b0 && mode_err == 1'b0 && flash_sel == 1'b0, "R1 reset flags",
            {boot_go, mode_err, flash_sel}, 0);

      // R2 external execution, power-on ignores skip bit (R1)
      skip_on_soft = 1'b1;
      por(3'b000);
      repeat (6) @(negedge clk);
      check(go_cnt == 1, "R2 one jump", go_cnt, 1);
      check(go_tgt == 32'h0200_0000, "R1 R2 external target", go_tgt, 32'h0200_0000);
      check(cs_falls == 0, "R2 no select", cs_falls, 0);
      skip_on_soft = 1'b0;

      // R3 reserved modes
      por(3'b101);
      repeat (30) @(negedge clk);
      check(mode_err == 1'b1, "R3 error flag 101", mode_err, 1);
      check(go_cnt == 0 && cs_falls == 0, "R3 quiet 101", go_cnt + cs_falls, 0);
      por(3'b111);
      repeat (30) @(negedge clk);
      check(mode_err == 1'b1, "R3 error flag 111", mode_err, 1);
      check(go_cnt == 0 && cs_falls == 0, "R3 quiet 111", go_cnt + cs_falls, 0);

      // R11 flash handoff
      por(3'b001);
      repeat (30) @(negedge clk);
      check(flash_sel == 1'b1 && mode_err == 1'b0, "R11 flash selected", {flash_sel, mode_err}, 2'b10);
      check(go_cnt == 0 && cs_falls == 0, "R11 no bus, no jump", go_cnt + cs_falls, 0);

      // R4 R5 R6 R7 serial loads
      run_spi(3'b010, 1, 5, 11, "mode010");
      run_spi(3'b011, 2, 3, 29, "mode011");
      // R6 length needing two header bytes, fills the whole space
      run_spi(3'b010, 1, 256, 5, "len256");

      // R8 zero length
      run_spi(3'b011, 2, 0, 1, "R8 zero length");
      check(cap_q.size() == 7, "R8 header only", cap_q.size(), 7);

      // R9 abort mid-command then resample
      por(3'b010);
      abytes = 1;
      load_img(4, 3);
      repeat (6) @(negedge clk);
      check(spi_cs_n == 1'b0, "R9 transfer running", spi_cs_n, 0);
      exp_q.delete();
      mode_pins = 3'b000;
      go_cnt = 0;
      soft_reset();
      check(spi_cs_n == 1'b1, "R9 cs released", spi_cs_n, 1);
      repeat (4) @(negedge clk);
      check(go_cnt == 1 && go_tgt == 32'h0200_0000, "R9 resampled to external", go_tgt, 32'h0200_0000);
      repeat (40) @(negedge clk);
      check(spi_sck == 1'b0 && spi_cs_n == 1'b1, "R9 bus stays idle", {spi_sck, spi_cs_n}, 2'b01);

      // R10 skip on software reset
      mode_pins = 3'b011;
      skip_on_soft = 1'b1;
      clear_obs();
      soft_reset();
      repeat (6) @(negedge clk);
      check(go_cnt == 1 && go_tgt == 32'h0, "R10 jump internal", go_tgt, 0);
      check(cs_falls == 0, "R10 no serial activity", cs_falls, 0);
      skip_on_soft = 1'b0;

      summary();
   end

endmodule